// File: doc/BRIEF.md
# Piecewise-Linear Sigmoid Unit

This unit squashes a signed fixed-point pre-activation sum into a fraction between zero and one, approximating the logistic function with five straight segments. The function path contains no multiplier and no table. It takes the magnitude of the input, evaluates one of two sloped segments with a constant right shift and a narrow fractional add, and saturates beyond eight in magnitude. For negative inputs it uses the symmetry y(−n) = 1 − y(n). A single multiplier forms the training derivative y·(1−y) from the squashed output. The stepwise slope of the approximation is not used as the derivative.

The unit sits at the output of a neuron's accumulator. The sum and a valid strobe go in. One clock later the squashed value, its derivative and a valid strobe come out. A parameter selects whether the input is coded in two's complement (the default) or sign-magnitude. Output registers load only on valid cycles and keep their value between them.

Top module: `pwl_sigmoid`

## Requirements
- R1: The input is 1+IBITS+FBITS bits wide (default 1+4+13 = 18). The output codes y_out and dy_out are unsigned FBITS-bit fractions, value = code / 2^FBITS. The full-scale input codes (−131072 and +131071 by default) map to 0 and 8191 with no wrap-around.
- R2: For |n| below THR = floor(1.6·2^FBITS) (13107 LSB by default), a non-negative input n gives y = floor(m/4) + 2^(FBITS−1), where m is the magnitude in LSB.
- R3: For THR ≤ n < 8·2^FBITS, y = floor(m/64) + 7·2^(FBITS−3).
- R4: A negative input of magnitude m below 8·2^FBITS gives y = 2^FBITS − p(m), where p is the positive-side value from R2 or R3.
- R5: A magnitude of 8·2^FBITS or more saturates the output: y = 2^FBITS − 1 for positive inputs and y = 0 for negative inputs.
- R6: With TWOS_COMP = 0, bit W−1 is the sign and the low W−1 bits are the magnitude. The sign-magnitude code 100…0 (negative zero) gives 2^(FBITS−1).
- R7: dy_out = floor(y·(2^FBITS − y) / 2^FBITS), computed from the registered y. It never exceeds 2^(FBITS−2).
- R8: out_valid follows in_valid with a latency of exactly one clock cycle. y_out and dy_out belong to the input presented in the cycle before.
- R9: When in_valid is low, the value on in_data has no effect, and y_out and dy_out keep their values.
- R10: While rst_n is low at a clock edge, out_valid, y_out and dy_out become 0 after that edge.
- R11: Over inputs in [−8, 8], the absolute difference between y_out/2^FBITS and the true logistic function stays below 0.07, and its mean stays below 0.03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data |
| in_data | input | 1+IBITS+FBITS | Pre-activation sum, signed fixed point |
| out_valid | output | 1 | Qualifies y_out and dy_out |
| y_out | output | FBITS | Squashed value, unsigned fraction |
| dy_out | output | FBITS | Derivative y·(1−y), unsigned fraction |

## Verification
The only state is the output register set, so any fault appears at the ports within one cycle. A wrong magnitude fold or segment selection shows up as a wrong y_out on the very next valid cycle after an input in the affected region. A register that loads when it should hold shows up on the first idle cycle whose in_data differs. The bench therefore drives inputs at every breakpoint (just below and at 1.6 and 8, both signs), at full scale, in both sign codings and at negative zero. It also inserts idle gaps with changing data and compares every output on every clock against a behavioural model.

// File: rtl/pwl_sig_pkg.sv
`timescale 1ns/1ps
// Shared types for the piecewise-linear sigmoid.
// Assumes nothing beyond being compiled before the modules that import it.
package pwl_sig_pkg;

    // Which piece of the positive half curve applies to a magnitude
    typedef enum logic [1:0] {
        SEG_CENTER = 2'd0,   // magnitude below the 1.6 breakpoint
        SEG_OUTER  = 2'd1,   // between 1.6 and 8
        SEG_SAT    = 2'd2    // 8 or beyond
    } seg_e;

    // Breakpoint 1.6 expressed in LSB of a format with fbits fraction bits
    function automatic int knee_lsb(input int fbits);
        return (16 << fbits) / 10;
    endfunction

endpackage

// File: rtl/pwl_sig_fold.sv
`timescale 1ns/1ps
// Input fold: splits the signed input into a sign flag and an unsigned
// magnitude. TWOS_COMP selects the coding. In two's-complement mode the
// inversion is followed by a one-LSB correction. Assumes W >= 3.
module pwl_sig_fold #(
    parameter int IBITS     = 4,
    parameter int FBITS     = 13,
    parameter bit TWOS_COMP = 1'b1,
    localparam int W        = 1 + IBITS + FBITS
) (
    input  logic [W-1:0] x_i,
    output logic         neg_o,
    output logic [W-1:0] mag_o
);

    generate
        if (TWOS_COMP) begin : g_twos
            // Negate through inversion plus one LSB when the sign bit is set
            always_comb begin
                neg_o = x_i[W-1];
                mag_o = neg_o ? (~x_i + {{(W-1){1'b0}}, 1'b1}) : x_i;
            end
        end else begin : g_signmag
            // Sign-magnitude: strip the sign bit, magnitude is the rest
            always_comb begin
                neg_o = x_i[W-1];
                mag_o = {1'b0, x_i[W-2:0]};
            end
        end
    endgenerate

endmodule

// File: rtl/pwl_sig_segments.sv
`timescale 1ns/1ps
// Positive half curve: picks the segment for a magnitude and forms its
// value with a constant shift and an add confined to the fraction bits.
// Assumes IBITS >= 4 so that the saturation point 8 is representable.
module pwl_sig_segments
    import pwl_sig_pkg::*;
#(
    parameter int IBITS = 4,
    parameter int FBITS = 13,
    localparam int W    = 1 + IBITS + FBITS
) (
    input  logic [W-1:0]     mag_i,
    output logic [FBITS-1:0] half_o,
    output seg_e             seg_o
);

    localparam logic [W-1:0]     SAT_LIM = W'(8) << FBITS;
    localparam logic [W-1:0]     KNEE    = W'(knee_lsb(FBITS));
    localparam logic [FBITS-1:0] OFS_MID = FBITS'(1) << (FBITS - 1);
    localparam logic [FBITS-1:0] OFS_OUT = FBITS'(7) << (FBITS - 3);

    logic [FBITS-1:0] mid_val;
    logic [FBITS-1:0] out_val;

    // Segment classification by magnitude
    always_comb begin
        if (mag_i >= SAT_LIM)   seg_o = SEG_SAT;
        else if (mag_i >= KNEE) seg_o = SEG_OUTER;
        else                    seg_o = SEG_CENTER;
    end

    // Slope 1/4 around zero, slope 1/64 in the outer piece
    always_comb begin
        mid_val = FBITS'(mag_i >> 2) + OFS_MID;
        out_val = FBITS'(mag_i >> 6) + OFS_OUT;
    end

    // Select the active segment value (saturation handled downstream)
    always_comb begin
        unique case (seg_o)
            SEG_CENTER: half_o = mid_val;
            SEG_OUTER:  half_o = out_val;
            default:    half_o = '1;
        endcase
    end

endmodule

// File: rtl/pwl_sig_unfold.sv
`timescale 1ns/1ps
// Output unfold: applies y(-n) = 1 - y(n) for negative inputs and pins the
// saturated extremes. Assumes half_i >= 0.5 whenever not saturated.
module pwl_sig_unfold
    import pwl_sig_pkg::*;
#(
    parameter int FBITS = 13
) (
    input  logic             neg_i,
    input  seg_e             seg_i,
    input  logic [FBITS-1:0] half_i,
    output logic [FBITS-1:0] y_o
);

    // Mirror or saturate the positive-side value
    always_comb begin
        if (seg_i == SEG_SAT)
            y_o = neg_i ? '0 : '1;
        else if (neg_i)
            y_o = ~half_i + {{(FBITS-1){1'b0}}, 1'b1};
        else
            y_o = half_i;
    end

endmodule

// File: rtl/pwl_sig_deriv.sv
`timescale 1ns/1ps
// Training derivative y*(1-y) from the squashed value, one multiplier.
// The result is truncated to FBITS fraction bits; it never exceeds 1/4.
module pwl_sig_deriv #(
    parameter int FBITS = 13,
    localparam int PW   = 2 * FBITS
) (
    input  logic [FBITS-1:0] y_i,
    output logic [FBITS-1:0] dy_o
);

    localparam logic [FBITS:0] ONE = (FBITS+1)'(1) << FBITS;

    logic [FBITS:0] comp;
    logic [PW-1:0]  prod;

    // Complement, product and rescale back to the fraction grid
    always_comb begin
        comp = ONE - {1'b0, y_i};
        prod = PW'(y_i) * PW'(comp);
        dy_o = FBITS'(prod >> FBITS);
    end

endmodule

// File: rtl/pwl_sigmoid.sv
`timescale 1ns/1ps
// Five-segment sigmoid with derivative, one register stage.
// Assumes a single clock, synchronous active-low reset, IBITS >= 4 and
// FBITS >= 3. Output registers load only on in_valid cycles.
module pwl_sigmoid
    import pwl_sig_pkg::*;
#(
    parameter int IBITS     = 4,
    parameter int FBITS     = 13,
    parameter bit TWOS_COMP = 1'b1,
    localparam int W        = 1 + IBITS + FBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_data,
    output logic             out_valid,
    output logic [FBITS-1:0] y_out,
    output logic [FBITS-1:0] dy_out
);

    logic             neg;
    logic [W-1:0]     mag;
    logic [FBITS-1:0] half;
    seg_e             seg;
    logic [FBITS-1:0] y_nxt;
    logic [FBITS-1:0] dy_nxt;

    pwl_sig_fold #(.IBITS(IBITS), .FBITS(FBITS), .TWOS_COMP(TWOS_COMP)) fold_i (
        .x_i   (in_data),
        .neg_o (neg),
        .mag_o (mag)
    );

    pwl_sig_segments #(.IBITS(IBITS), .FBITS(FBITS)) seg_i (
        .mag_i  (mag),
        .half_o (half),
        .seg_o  (seg)
    );

    pwl_sig_unfold #(.FBITS(FBITS)) unfold_i (
        .neg_i  (neg),
        .seg_i  (seg),
        .half_i (half),
        .y_o    (y_nxt)
    );

    pwl_sig_deriv #(.FBITS(FBITS)) deriv_i (
        .y_i  (y_nxt),
        .dy_o (dy_nxt)
    );

    // Output stage: valid pipeline and data capture on valid cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_out     <= '0;
            dy_out    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_out  <= y_nxt;
                dy_out <= dy_nxt;
            end
        end
    end

endmodule

// File: rtl/pwl_sigmoid_chk.sv
`timescale 1ns/1ps
// Property checker for pwl_sigmoid, attached by bind below.
module pwl_sigmoid_chk #(
    parameter int IBITS     = 4,
    parameter int FBITS     = 13,
    parameter bit TWOS_COMP = 1'b1,
    localparam int W        = 1 + IBITS + FBITS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     in_data,
    input logic             out_valid,
    input logic [FBITS-1:0] y_out,
    input logic [FBITS-1:0] dy_out
);

    localparam int               LIM_I   = 8 << FBITS;
    localparam logic [FBITS-1:0] QUARTER = FBITS'(1) << (FBITS - 2);

    int   sval;
    int   smag;
    logic pos_big;
    logic neg_big;

    // Decode the input coding into "far positive" and "far negative" flags
    always_comb begin
        sval = int'($signed(in_data));
        smag = int'(in_data[W-2:0]);
        if (TWOS_COMP) begin
            pos_big = (sval >= LIM_I);
            neg_big = (sval <= -LIM_I);
        end else begin
            pos_big = !in_data[W-1] && (smag >= LIM_I);
            neg_big =  in_data[W-1] && (smag >= LIM_I);
        end
    end

    // R8
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y_out) && $stable(dy_out)));
    // R5
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pos_big) |=> (y_out == '1));
    // R5
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && neg_big) |=> (y_out == '0));
    // R7
    deriv_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dy_out <= QUARTER));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && y_out == '0 && dy_out == '0));

endmodule

bind pwl_sigmoid pwl_sigmoid_chk #(
    .IBITS(IBITS), .FBITS(FBITS), .TWOS_COMP(TWOS_COMP)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .y_out     (y_out),
    .dy_out    (dy_out)
);

// File: tb/pwl_sigmoid_tb_top.sv
`timescale 1ns/1ps
module pwl_sigmoid_tb_top;

    localparam int F    = 13;
    localparam int W    = 18;
    localparam int ONE  = 1 << F;
    localparam int LIM  = 8 << F;
    localparam int KNEE = 13107;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tb_valid = 1'b0;
    logic [W-1:0] tb_x = '0;
    logic [W-1:0] tb_xs = '0;

    logic         ov_a, ov_b;
    logic [F-1:0] y_a, y_b, d_a, d_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    pwl_sigmoid dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(tb_valid), .in_data(tb_x),
        .out_valid(ov_a), .y_out(y_a), .dy_out(d_a));

    pwl_sigmoid #(.TWOS_COMP(1'b0)) dut_sm (
        .clk(clk), .rst_n(rst_n), .in_valid(tb_valid), .in_data(tb_xs),
        .out_valid(ov_b), .y_out(y_b), .dy_out(d_b));

    // Reference curve from the requirements (R2 R3 R4 R5)
    function automatic int pos_ref(input int m);
        if (m >= LIM)  return ONE - 1;
        if (m < KNEE)  return m / 4 + ONE / 2;
        return m / 64 + 7 * ONE / 8;
    endfunction

    function automatic int sig_ref(input int v, input bit negative);
        int m = (v < 0) ? -v : v;
        if (m >= LIM) return negative ? 0 : ONE - 1;
        return negative ? ONE - pos_ref(m) : pos_ref(m);
    endfunction

    // R7 reference
    function automatic int der_ref(input int y);
        return (y * (ONE - y)) / ONE;
    endfunction

    function automatic string tag_of(input int v);
        int m = (v < 0) ? -v : v;
        if (v == 131071 || v == -131072) return "R1";
        if (m >= LIM)  return "R5";
        if (v < 0)     return "R4";
        if (m >= KNEE) return "R3";
        return "R2";
    endfunction

    // Behavioural expected outputs, advanced once per clock
    int    e_ya, e_da, e_yb, e_db;
    bit    e_va;
    string t_a, t_b;

    always @(posedge clk) begin
        int va, vb;
        started <= 1'b1;
        va = int'($signed(tb_x));
        vb = tb_xs[W-1] ? -int'(tb_xs[W-2:0]) : int'(tb_xs[W-2:0]);
        if (!rst_n) begin
            e_va <= 1'b0; e_ya <= 0; e_da <= 0; e_yb <= 0; e_db <= 0;
            t_a <= "R10"; t_b <= "R10";
        end else begin
            e_va <= tb_valid;
            if (tb_valid) begin
                e_ya <= sig_ref(va, va < 0);
                e_da <= der_ref(sig_ref(va, va < 0));
                e_yb <= sig_ref(vb, tb_xs[W-1]);
                e_db <= der_ref(sig_ref(vb, tb_xs[W-1]));
                t_a  <= tag_of(va);
                t_b  <= "R6";
            end else begin
                t_a <= "R9"; t_b <= "R9";
            end
        end
    end

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            cmp(t_a == "R10" ? "R10" : "R8", "valid", 32'(ov_a), 32'(e_va));
            cmp(t_a == "R10" ? "R10" : "R8", "valid_sm", 32'(ov_b), 32'(e_va));
            cmp(t_a, "y", 32'(y_a), 32'(e_ya));
            cmp(t_a == "R10" ? "R10" : "R7", "dy", 32'(d_a), 32'(e_da));
            cmp(t_b, "y_sm", 32'(y_b), 32'(e_yb));
            cmp(t_b == "R10" ? "R10" : "R7", "dy_sm", 32'(d_b), 32'(e_db));
        end
    end

    task automatic put(input int v);
        int m = (v < 0) ? -v : v;
        if (m > 131071) m = 131071;
        @(negedge clk);
        tb_valid = 1'b1;
        tb_x  = W'(v);
        tb_xs = {v < 0, 17'(m)};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tb_valid = 1'b0;
            tb_x  = W'($urandom);
            tb_xs = W'($urandom);
        end
    endtask

    real err_max = 0.0;
    real err_sum = 0.0;
    int  npts = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 R3 R4 R5 R1 breakpoints and extremes
        foreach (dirs[i]) put(dirs[i]);
        idle(4);                                  // R9 idle with noise
        put(20000); idle(3); put(-5000); idle(2);
        // R6 negative zero in sign-magnitude coding
        @(negedge clk); tb_valid = 1'b1; tb_x = '0; tb_xs = 18'h20000;
        for (int i = 0; i < 400; i++) begin
            put(int'($urandom_range(0, 262143)) - 131072);
            if (i % 37 == 0) idle(1);
        end
        // R10 reset in mid-stream with valid high
        @(negedge clk); rst_n = 1'b0; tb_valid = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R11 error sweep against the true logistic
        for (int v = -LIM; v <= LIM; v += 256) begin
            real xr, s, e;
            put(v);
            @(posedge clk); #1;
            xr = real'(v) / real'(ONE);
            s  = 1.0 / (1.0 + $exp(-xr));
            e  = real'(y_a) / real'(ONE) - s;
            if (e < 0.0) e = -e;
            if (e > err_max) err_max = e;
            err_sum += e;
            npts++;
        end
        idle(2);
        checks++;
        if (err_max >= 0.07) begin
            errors++;
            $display("FAIL R11 max error actual=%f expected<0.07", err_max);
        end
        checks++;
        if (err_sum / npts >= 0.03) begin
            errors++;
            $display("FAIL R11 mean error actual=%f expected<0.03", err_sum / npts);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int dirs[] = '{0, 1, -1, 4096, -4096, KNEE - 1, KNEE, -KNEE, -(KNEE - 1),
                   30000, -30000, LIM - 1, LIM, -LIM, -(LIM - 1),
                   131071, -131072, 100000, -100000};

    // Watchdog: a hung run counts as a failure
    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule